// File: doc/BRIEF.md
# Home directory protocol controller

This block is the coherence controller that sits at the home node of a line range. It keeps one directory entry per line in a small array of `LINES` entries. Each entry holds a state, an owner pointer, a pending-requestor pointer and a presence vector with one bit per node. Each cycle it accepts at most one incoming message: a request (read, read-exclusive, upgrade, writeback), a revision sent back by a former owner, or a poison command used by page migration. It updates the addressed entry. One cycle later it issues at most one reply, one forwarded message and one invalidation mask.

The protocol uses reply forwarding. A request to a line held exclusively elsewhere gets a speculative data reply at once. An intervention naming the requestor goes to the owner, and the entry goes busy until the owner's revision arrives. Sharers invalidated on a write acknowledge the requestor directly, so the reply only carries how many acknowledgements to expect. Requests that find a busy entry are refused so that no buffer is tied up. A writeback that crosses an intervention is merged: the data goes on to the waiting requestor and the writer is acknowledged. The network is not assumed to keep point-to-point order. Data movement is modelled by message kind only.

Top module: `home_dir_ctl`

## Requirements
- R1: After reset every entry is unowned and no output is valid. With `in_valid` low, no output is valid in the next cycle.
- R2: A read (type 0), read-exclusive (type 1) or upgrade (type 2) that finds its entry busy (state codes 3, 4, 5) gets a NACK reply (kind 4) to the sender and changes nothing.
- R3: A read to an unowned entry makes the sender exclusive owner and replies exclusive-data (kind 1, count 0). A read to a shared entry adds the sender's presence bit and replies shared-data (kind 0).
- R4: A read-exclusive to an unowned entry makes the sender owner, with only its presence bit set, and replies exclusive-data (kind 1) with count 0.
- R5: A read or read-exclusive to an exclusive entry does all of the following. It records the sender as pending requestor, clears the owner's bit and sets the sender's bit, and moves to busy-shared (read) or busy-exclusive (read-exclusive). It replies speculative data (kind 3) to the sender. It forwards an intervention to the owner naming the sender: kind 0 for a read, kind 1 for a read-exclusive.
- R6: A sharing writeback (type 4) or downgrade (type 5) to a busy-shared entry makes it shared and adds the sender's bit. An ownership transfer (type 6) to a busy-exclusive entry makes it exclusive, owned by the pending requestor. Revisions produce no output.
- R7: An upgrade to an unowned or exclusive entry is NACKed (kind 4) and changes nothing.
- R8: A read-exclusive or upgrade to a shared entry makes the sender exclusive owner. The reply is exclusive-data (kind 1) for a read-exclusive or upgrade-ack (kind 2) for an upgrade, and carries the count of other sharers. When that count is non-zero, an invalidation mask of exactly those sharers is issued.
- R9: A writeback (type 3) to an exclusive entry makes it unowned and replies writeback-ack (kind 5) to the writer.
- R10: A writeback to a busy-shared or busy-exclusive entry makes it shared or exclusive (owner = pending requestor). It forwards the written data to the pending requestor (kind 2 for shared, 3 for exclusive, naming the writer) and replies writeback-ack (kind 5) to the writer.
- R11: A poison command (type 7) to an unowned entry poisons it with no output. Any read, read-exclusive or upgrade to a poisoned entry gets a poisoned reply (kind 6).
- R12: A line index at or above `LINES`, a type code above 7, or a message not legal in the entry's state raises `err` for one cycle with no other output and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message present |
| in_type | input | 4 | Message type code |
| in_src | input | NODE_W | Sending node |
| in_line | input | LINE_W | Line index into the entry array |
| rsp_valid | output | 1 | Reply present |
| rsp_kind | output | 3 | Reply kind |
| rsp_dst | output | NODE_W | Reply destination node |
| rsp_inv_cnt | output | CNT_W | Acknowledgements the requestor must collect |
| fwd_valid | output | 1 | Forwarded message present |
| fwd_kind | output | 2 | Intervention or forwarded writeback kind |
| fwd_dst | output | NODE_W | Forward destination |
| fwd_about | output | NODE_W | Node the forward concerns (requestor or writer) |
| inv_valid | output | 1 | Invalidations present |
| inv_mask | output | NODES | Nodes to invalidate |
| err | output | 1 | Illegal or out-of-range message seen |

## Verification
Assertions check the following on every cycle. A busy entry always yields a NACK. An invalidation mask never includes the requestor and always matches the reply's count. Every intervention is paired with a speculative reply to the node it names. Every forwarded writeback is paired with an ack to the writer. An out-of-range line gives a lone error. The state sequences need the bench's scenarios and its per-cycle reference model. These are the three-party exchange through a busy state, the writeback crossing an intervention, revision-driven exits from busy, poisoning, and the proof that a refused or erroneous message left the entry untouched.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

    typedef enum logic [2:0] {
        ST_UNOWNED = 3'd0,
        ST_SHARED  = 3'd1,
        ST_EXCL    = 3'd2,
        ST_BUSY_UN = 3'd3,
        ST_BUSY_SH = 3'd4,
        ST_BUSY_EX = 3'd5,
        ST_POISON  = 3'd6
    } dstate_e;

    typedef enum logic [3:0] {
        MSG_READ   = 4'd0,
        MSG_RDEX   = 4'd1,
        MSG_UPGR   = 4'd2,
        MSG_WB     = 4'd3,
        MSG_SHWB   = 4'd4,
        MSG_DOWN   = 4'd5,
        MSG_XFER   = 4'd6,
        MSG_POISON = 4'd7
    } msg_e;

    typedef enum logic [2:0] {
        RSP_SH_DATA  = 3'd0,
        RSP_EX_DATA  = 3'd1,
        RSP_UPG_ACK  = 3'd2,
        RSP_SPEC     = 3'd3,
        RSP_NACK     = 3'd4,
        RSP_WB_ACK   = 3'd5,
        RSP_POISONED = 3'd6
    } rsp_e;

    typedef enum logic [1:0] {
        FWD_INTV_SH = 2'd0,
        FWD_INTV_EX = 2'd1,
        FWD_WBD_SH  = 2'd2,
        FWD_WBD_EX  = 2'd3
    } fwd_e;

    function automatic logic is_busy(dstate_e s);
        return (s == ST_BUSY_UN) || (s == ST_BUSY_SH) || (s == ST_BUSY_EX);
    endfunction

endpackage

// File: rtl/hdc_decode.sv
module hdc_decode
    import hdc_pkg::*;
#(
    parameter int LINES  = 12,
    parameter int LINE_W = 4
) (
    input  logic              valid,
    input  logic [3:0]        mtype,
    input  logic [LINE_W-1:0] line,
    output logic              act,
    output logic              bad,
    output msg_e              msg
);
    localparam logic [LINE_W:0] LIMIT = (LINE_W+1)'(LINES);

    logic known;
    logic in_range;

    always_comb begin
        known    = (mtype <= 4'd7);
        in_range = ({1'b0, line} < LIMIT);
        msg      = msg_e'(mtype);
        act      = valid & known & in_range;
        bad      = valid & ~(known & in_range);
    end
endmodule

// File: rtl/hdc_popcnt.sv
module hdc_popcnt #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic [N:0][CW-1:0] part;

    assign part[0] = '0;
    for (genvar gi = 0; gi < N; gi++) begin : g_sum
        assign part[gi+1] = part[gi] + CW'(vec[gi]);
    end
    assign cnt = part[N];
endmodule

// File: rtl/hdc_next.sv
module hdc_next
    import hdc_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int NODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              act,
    input  msg_e              msg,
    input  logic [NODE_W-1:0] src,
    input  dstate_e           cur_st,
    input  logic [NODE_W-1:0] cur_own,
    input  logic [NODE_W-1:0] cur_pend,
    input  logic [NODES-1:0]  cur_vec,
    output logic              wr,
    output dstate_e           nx_st,
    output logic [NODE_W-1:0] nx_own,
    output logic [NODE_W-1:0] nx_pend,
    output logic [NODES-1:0]  nx_vec,
    output logic              rsp_v,
    output rsp_e              rsp_k,
    output logic [NODE_W-1:0] rsp_dst,
    output logic [CNT_W-1:0]  rsp_cnt,
    output logic              fwd_v,
    output fwd_e              fwd_k,
    output logic [NODE_W-1:0] fwd_dst,
    output logic [NODE_W-1:0] fwd_about,
    output logic              inv_v,
    output logic [NODES-1:0]  inv_m,
    output logic              err
);
    logic [NODES-1:0] src_bit;
    logic [NODES-1:0] own_bit;
    logic [NODES-1:0] others;
    logic [CNT_W-1:0] others_cnt;

    assign src_bit = NODES'(1) << src;
    assign own_bit = NODES'(1) << cur_own;
    assign others  = cur_vec & ~src_bit;

    hdc_popcnt #(.N(NODES), .CW(CNT_W)) i_cnt (
        .vec (others),
        .cnt (others_cnt)
    );

    always_comb begin
        wr        = 1'b0;
        nx_st     = cur_st;
        nx_own    = cur_own;
        nx_pend   = cur_pend;
        nx_vec    = cur_vec;
        rsp_v     = 1'b0;
        rsp_k     = RSP_NACK;
        rsp_dst   = src;
        rsp_cnt   = '0;
        fwd_v     = 1'b0;
        fwd_k     = FWD_INTV_SH;
        fwd_dst   = cur_own;
        fwd_about = src;
        inv_v     = 1'b0;
        inv_m     = others;
        err       = 1'b0;
        if (act) begin
            case (cur_st)
                ST_UNOWNED: begin
                    case (msg)
                        MSG_READ, MSG_RDEX: begin
                            wr     = 1'b1;
                            nx_st  = ST_EXCL;
                            nx_own = src;
                            nx_vec = src_bit;
                            rsp_v  = 1'b1;
                            rsp_k  = RSP_EX_DATA;
                        end
                        MSG_UPGR: rsp_v = 1'b1;
                        MSG_POISON: begin
                            wr     = 1'b1;
                            nx_st  = ST_POISON;
                            nx_vec = '0;
                        end
                        default: err = 1'b1;
                    endcase
                end
                ST_SHARED: begin
                    case (msg)
                        MSG_READ: begin
                            wr     = 1'b1;
                            nx_vec = cur_vec | src_bit;
                            rsp_v  = 1'b1;
                            rsp_k  = RSP_SH_DATA;
                        end
                        MSG_RDEX, MSG_UPGR: begin
                            wr      = 1'b1;
                            nx_st   = ST_EXCL;
                            nx_own  = src;
                            nx_vec  = src_bit;
                            rsp_v   = 1'b1;
                            rsp_k   = (msg == MSG_RDEX) ? RSP_EX_DATA : RSP_UPG_ACK;
                            rsp_cnt = others_cnt;
                            inv_v   = |others;
                        end
                        default: err = 1'b1;
                    endcase
                end
                ST_EXCL: begin
                    case (msg)
                        MSG_READ, MSG_RDEX: begin
                            wr      = 1'b1;
                            nx_st   = (msg == MSG_READ) ? ST_BUSY_SH : ST_BUSY_EX;
                            nx_pend = src;
                            nx_vec  = (cur_vec & ~own_bit) | src_bit;
                            rsp_v   = 1'b1;
                            rsp_k   = RSP_SPEC;
                            fwd_v   = 1'b1;
                            fwd_k   = (msg == MSG_READ) ? FWD_INTV_SH : FWD_INTV_EX;
                        end
                        MSG_UPGR: rsp_v = 1'b1;
                        MSG_WB: begin
                            wr     = 1'b1;
                            nx_st  = ST_UNOWNED;
                            nx_vec = '0;
                            rsp_v  = 1'b1;
                            rsp_k  = RSP_WB_ACK;
                        end
                        default: err = 1'b1;
                    endcase
                end
                ST_BUSY_UN, ST_BUSY_SH, ST_BUSY_EX: begin
                    case (msg)
                        MSG_READ, MSG_RDEX, MSG_UPGR: rsp_v = 1'b1;
                        MSG_WB: begin
                            if (cur_st == ST_BUSY_UN) begin
                                err = 1'b1;
                            end else begin
                                wr      = 1'b1;
                                nx_st   = (cur_st == ST_BUSY_SH) ? ST_SHARED : ST_EXCL;
                                nx_own  = (cur_st == ST_BUSY_EX) ? cur_pend : cur_own;
                                rsp_v   = 1'b1;
                                rsp_k   = RSP_WB_ACK;
                                fwd_v   = 1'b1;
                                fwd_k   = (cur_st == ST_BUSY_SH) ? FWD_WBD_SH : FWD_WBD_EX;
                                fwd_dst = cur_pend;
                            end
                        end
                        MSG_SHWB, MSG_DOWN: begin
                            if (cur_st == ST_BUSY_SH) begin
                                wr     = 1'b1;
                                nx_st  = ST_SHARED;
                                nx_vec = cur_vec | src_bit;
                            end else begin
                                err = 1'b1;
                            end
                        end
                        MSG_XFER: begin
                            if (cur_st == ST_BUSY_EX) begin
                                wr     = 1'b1;
                                nx_st  = ST_EXCL;
                                nx_own = cur_pend;
                            end else begin
                                err = 1'b1;
                            end
                        end
                        default: err = 1'b1;
                    endcase
                end
                ST_POISON: begin
                    case (msg)
                        MSG_READ, MSG_RDEX, MSG_UPGR: begin
                            rsp_v = 1'b1;
                            rsp_k = RSP_POISONED;
                        end
                        default: err = 1'b1;
                    endcase
                end
                default: err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/home_dir_ctl.sv
module home_dir_ctl
    import hdc_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int LINES  = 12,
    parameter int LINE_W = 4,
    localparam int NODE_W = $clog2(NODES),
    localparam int CNT_W  = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_type,
    input  logic [NODE_W-1:0] in_src,
    input  logic [LINE_W-1:0] in_line,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [NODE_W-1:0] rsp_dst,
    output logic [CNT_W-1:0]  rsp_inv_cnt,
    output logic              fwd_valid,
    output logic [1:0]        fwd_kind,
    output logic [NODE_W-1:0] fwd_dst,
    output logic [NODE_W-1:0] fwd_about,
    output logic              inv_valid,
    output logic [NODES-1:0]  inv_mask,
    output logic              err
);
    localparam logic [LINE_W:0] LIMIT = (LINE_W+1)'(LINES);

    typedef struct packed {
        dstate_e           st;
        logic [NODE_W-1:0] own;
        logic [NODE_W-1:0] pend;
        logic [NODES-1:0]  vec;
    } entry_t;

    typedef struct packed {
        logic              rv;
        rsp_e              rk;
        logic [NODE_W-1:0] rd;
        logic [CNT_W-1:0]  rc;
        logic              fv;
        fwd_e              fk;
        logic [NODE_W-1:0] fd;
        logic [NODE_W-1:0] fa;
        logic              iv;
        logic [NODES-1:0]  im;
        logic              er;
    } out_t;

    typedef struct packed {
        entry_t [LINES-1:0] ent;
        out_t               o;
    } state_t;

    state_t s_d, s_q;
    entry_t cur;

    logic dec_act, dec_bad;
    msg_e dec_msg;

    logic              n_wr, n_rv, n_fv, n_iv, n_err;
    dstate_e           n_st;
    logic [NODE_W-1:0] n_own, n_pend, n_rd, n_fd, n_fa;
    logic [NODES-1:0]  n_vec, n_im;
    rsp_e              n_rk;
    fwd_e              n_fk;
    logic [CNT_W-1:0]  n_rc;

    hdc_decode #(.LINES(LINES), .LINE_W(LINE_W)) i_dec (
        .valid (in_valid),
        .mtype (in_type),
        .line  (in_line),
        .act   (dec_act),
        .bad   (dec_bad),
        .msg   (dec_msg)
    );

    always_comb begin
        cur = '0;
        for (int i = 0; i < LINES; i++) begin
            if (in_line == LINE_W'(i)) cur = s_q.ent[i];
        end
    end

    hdc_next #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) i_next (
        .act       (dec_act),
        .msg       (dec_msg),
        .src       (in_src),
        .cur_st    (cur.st),
        .cur_own   (cur.own),
        .cur_pend  (cur.pend),
        .cur_vec   (cur.vec),
        .wr        (n_wr),
        .nx_st     (n_st),
        .nx_own    (n_own),
        .nx_pend   (n_pend),
        .nx_vec    (n_vec),
        .rsp_v     (n_rv),
        .rsp_k     (n_rk),
        .rsp_dst   (n_rd),
        .rsp_cnt   (n_rc),
        .fwd_v     (n_fv),
        .fwd_k     (n_fk),
        .fwd_dst   (n_fd),
        .fwd_about (n_fa),
        .inv_v     (n_iv),
        .inv_m     (n_im),
        .err       (n_err)
    );

    always_comb begin
        s_d      = s_q;
        s_d.o.rv = n_rv;
        s_d.o.rk = n_rk;
        s_d.o.rd = n_rd;
        s_d.o.rc = n_rc;
        s_d.o.fv = n_fv;
        s_d.o.fk = n_fk;
        s_d.o.fd = n_fd;
        s_d.o.fa = n_fa;
        s_d.o.iv = n_iv;
        s_d.o.im = n_im;
        s_d.o.er = dec_bad | n_err;
        for (int i = 0; i < LINES; i++) begin
            if (n_wr && in_line == LINE_W'(i)) begin
                s_d.ent[i].st   = n_st;
                s_d.ent[i].own  = n_own;
                s_d.ent[i].pend = n_pend;
                s_d.ent[i].vec  = n_vec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid   = s_q.o.rv;
    assign rsp_kind    = s_q.o.rk;
    assign rsp_dst     = s_q.o.rd;
    assign rsp_inv_cnt = s_q.o.rc;
    assign fwd_valid   = s_q.o.fv;
    assign fwd_kind    = s_q.o.fk;
    assign fwd_dst     = s_q.o.fd;
    assign fwd_about   = s_q.o.fa;
    assign inv_valid   = s_q.o.iv;
    assign inv_mask    = s_q.o.im;
    assign err         = s_q.o.er;

    a_r2_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_act && (dec_msg inside {MSG_READ, MSG_RDEX, MSG_UPGR}) && is_busy(cur.st))
        |=> (rsp_valid && rsp_kind == RSP_NACK));

    a_r8_inv_count: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (rsp_valid && $countones(inv_mask) == int'(rsp_inv_cnt)));

    a_r8_inv_skips_requestor: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !inv_mask[rsp_dst]);

    a_r5_intv_paired: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_kind[1]) |-> (rsp_valid && rsp_kind == RSP_SPEC && rsp_dst == fwd_about));

    a_r10_merge_paired: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_kind[1]) |-> (rsp_valid && rsp_kind == RSP_WB_ACK && rsp_dst == fwd_about));

    a_r12_bad_line: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ({1'b0, in_line} >= LIMIT))
        |=> (err && !rsp_valid && !fwd_valid && !inv_valid));
endmodule

// File: tb/test_home_dir_ctl.sv
module test_home_dir_ctl;
    localparam int NODES = 8, LINES = 12, LINE_W = 4, NODE_W = 3, CNT_W = 4;
    localparam int S_UN = 0, S_SH = 1, S_EX = 2, S_BSH = 4, S_BEX = 5, S_PO = 6;
    localparam int K_SH = 0, K_EXD = 1, K_UPG = 2, K_SPEC = 3, K_NACK = 4, K_WBA = 5, K_POI = 6;
    localparam int T_RD = 0, T_RDX = 1, T_UPG = 2, T_WB = 3, T_SHWB = 4, T_DN = 5, T_XF = 6, T_PO = 7;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0;
    logic [3:0] in_type = 0;
    logic [NODE_W-1:0] in_src = 0;
    logic [LINE_W-1:0] in_line = 0;
    logic rsp_valid, fwd_valid, inv_valid, err;
    logic [2:0] rsp_kind;
    logic [1:0] fwd_kind;
    logic [NODE_W-1:0] rsp_dst, fwd_dst, fwd_about;
    logic [CNT_W-1:0] rsp_inv_cnt;
    logic [NODES-1:0] inv_mask;

    always #10 clk = ~clk;

    home_dir_ctl #(.NODES(NODES), .LINES(LINES), .LINE_W(LINE_W)) i_home_dir_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_src(in_src), .in_line(in_line), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_dst(rsp_dst), .rsp_inv_cnt(rsp_inv_cnt),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_dst(fwd_dst),
        .fwd_about(fwd_about), .inv_valid(inv_valid), .inv_mask(inv_mask), .err(err)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;

    int m_st[LINES], m_own[LINES], m_pend[LINES];
    bit [NODES-1:0] m_vec[LINES];

    int e_rv, e_rk, e_rd, e_rc, e_fv, e_fk, e_fd, e_fa, e_iv, e_err;
    bit [NODES-1:0] e_im;
    string e_tag = "R1";

    task automatic chk(bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", e_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(int'(rsp_valid) == e_rv, "rsp_valid", int'(rsp_valid), e_rv);
        if (e_rv != 0) begin
            chk(int'(rsp_kind) == e_rk, "rsp_kind", int'(rsp_kind), e_rk);
            chk(int'(rsp_dst) == e_rd, "rsp_dst", int'(rsp_dst), e_rd);
            chk(int'(rsp_inv_cnt) == e_rc, "rsp_inv_cnt", int'(rsp_inv_cnt), e_rc);
        end
        chk(int'(fwd_valid) == e_fv, "fwd_valid", int'(fwd_valid), e_fv);
        if (e_fv != 0) begin
            chk(int'(fwd_kind) == e_fk, "fwd_kind", int'(fwd_kind), e_fk);
            chk(int'(fwd_dst) == e_fd, "fwd_dst", int'(fwd_dst), e_fd);
            chk(int'(fwd_about) == e_fa, "fwd_about", int'(fwd_about), e_fa);
        end
        chk(int'(inv_valid) == e_iv, "inv_valid", int'(inv_valid), e_iv);
        if (e_iv != 0) chk(inv_mask == e_im, "inv_mask", int'(inv_mask), int'(e_im));
        chk(int'(err) == e_err, "err", int'(err), e_err);
    endtask

    function automatic int ones(bit [NODES-1:0] v);
        int c = 0;
        for (int i = 0; i < NODES; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic rsp(int k, int d, int c);
        e_rv = 1; e_rk = k; e_rd = d; e_rc = c;
    endtask

    task automatic model(bit v, int t, int s, int l);
        bit [NODES-1:0] sb;
        int st;
        e_rv = 0; e_fv = 0; e_iv = 0; e_err = 0; e_tag = "R1";
        if (!v) return;
        if (t > 7 || l >= LINES) begin e_err = 1; e_tag = "R12"; return; end
        sb = 1 << s;
        st = m_st[l];
        if (st == S_BSH || st == S_BEX) begin
            if (t <= T_UPG) begin rsp(K_NACK, s, 0); e_tag = "R2"; end
            else if (t == T_WB) begin
                e_tag = "R10";
                rsp(K_WBA, s, 0);
                e_fv = 1; e_fd = m_pend[l]; e_fa = s;
                e_fk = (st == S_BSH) ? 2 : 3;
                if (st == S_BSH) m_st[l] = S_SH;
                else begin m_st[l] = S_EX; m_own[l] = m_pend[l]; end
            end else if ((t == T_SHWB || t == T_DN) && st == S_BSH) begin
                e_tag = "R6"; m_st[l] = S_SH; m_vec[l] |= sb;
            end else if (t == T_XF && st == S_BEX) begin
                e_tag = "R6"; m_st[l] = S_EX; m_own[l] = m_pend[l];
            end else begin e_err = 1; e_tag = "R12"; end
        end else if (st == S_UN) begin
            if (t == T_RD || t == T_RDX) begin
                e_tag = (t == T_RD) ? "R3" : "R4";
                rsp(K_EXD, s, 0);
                m_st[l] = S_EX; m_own[l] = s; m_vec[l] = sb;
            end else if (t == T_UPG) begin rsp(K_NACK, s, 0); e_tag = "R7"; end
            else if (t == T_PO) begin e_tag = "R11"; m_st[l] = S_PO; m_vec[l] = '0; end
            else begin e_err = 1; e_tag = "R12"; end
        end else if (st == S_SH) begin
            if (t == T_RD) begin e_tag = "R3"; rsp(K_SH, s, 0); m_vec[l] |= sb; end
            else if (t == T_RDX || t == T_UPG) begin
                bit [NODES-1:0] oth;
                oth = m_vec[l] & ~sb;
                e_tag = "R8";
                rsp((t == T_RDX) ? K_EXD : K_UPG, s, ones(oth));
                if (oth != 0) begin e_iv = 1; e_im = oth; end
                m_st[l] = S_EX; m_own[l] = s; m_vec[l] = sb;
            end else begin e_err = 1; e_tag = "R12"; end
        end else if (st == S_EX) begin
            if (t == T_RD || t == T_RDX) begin
                e_tag = "R5";
                rsp(K_SPEC, s, 0);
                e_fv = 1; e_fk = (t == T_RD) ? 0 : 1; e_fd = m_own[l]; e_fa = s;
                m_vec[l] = (m_vec[l] & ~(NODES'(1) << m_own[l])) | sb;
                m_pend[l] = s;
                m_st[l] = (t == T_RD) ? S_BSH : S_BEX;
            end else if (t == T_UPG) begin rsp(K_NACK, s, 0); e_tag = "R7"; end
            else if (t == T_WB) begin
                e_tag = "R9"; rsp(K_WBA, s, 0); m_st[l] = S_UN; m_vec[l] = '0;
            end else begin e_err = 1; e_tag = "R12"; end
        end else begin
            if (t <= T_UPG) begin rsp(K_POI, s, 0); e_tag = "R11"; end
            else begin e_err = 1; e_tag = "R12"; end
        end
    endtask

    task automatic step(bit v, int t, int s, int l);
        @(negedge clk);
        compare();
        model(v, t, s, l);
        in_valid = v; in_type = 4'(t); in_src = NODE_W'(s); in_line = LINE_W'(l);
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_st[i] = S_UN; m_own[i] = 0; m_pend[i] = 0; m_vec[i] = '0;
        end
        e_rv = 0; e_fv = 0; e_iv = 0; e_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step(0, 0, 0, 0);                 // R1 reset outputs idle
        // line 0: R3, R5, R2, R6, R3, R8
        step(1, T_RD, 1, 0);
        step(1, T_RD, 2, 0);
        step(1, T_RD, 3, 0);
        step(1, T_UPG, 3, 0);
        step(1, T_DN, 1, 0);
        step(1, T_RD, 4, 0);
        step(1, T_UPG, 2, 0);
        step(0, 0, 0, 0);
        // line 1: R4, R7, R5, R10, R9, R7
        step(1, T_RDX, 0, 1);
        step(1, T_UPG, 5, 1);
        step(1, T_RDX, 5, 1);
        step(1, T_WB, 0, 1);
        step(1, T_WB, 5, 1);
        step(1, T_UPG, 2, 1);
        // line 2: writeback merged into busy-shared, then R8
        step(1, T_RD, 3, 2);
        step(1, T_RD, 6, 2);
        step(1, T_WB, 3, 2);
        step(1, T_RDX, 7, 2);
        // line 3: R6 ownership transfer then R5 to new owner
        step(1, T_RDX, 1, 3);
        step(1, T_RDX, 2, 3);
        step(1, T_XF, 1, 3);
        step(1, T_RD, 4, 3);
        step(1, T_SHWB, 2, 3);
        // R12 errors, then prove line 5 untouched
        step(1, T_RD, 0, 12);
        step(1, 9, 0, 5);
        step(1, T_WB, 0, 5);
        step(1, T_SHWB, 0, 5);
        step(1, T_RD, 0, 5);
        // R11 poison
        step(1, T_PO, 0, 6);
        step(1, T_RD, 3, 6);
        step(1, T_UPG, 3, 6);
        step(1, T_PO, 0, 0);
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            int t, l;
            t = $urandom_range(0, 9);
            l = $urandom_range(0, 13);
            if (t == T_PO && $urandom_range(0, 3) != 0) t = T_RD;
            step($urandom_range(0, 7) != 0, t, $urandom_range(0, NODES - 1), l);
        end
        step(0, 0, 0, 0);
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule